// File: doc/BRIEF.md
# Speculative Carry Variable-Latency Adder

This block is a clocked two's-complement adder whose completion time depends on its operands. The word is cut into equal sections that all add in the same cycle. The carry into each upper section is guessed from one bit pair: the top operand bits of the section just below it. When every guess matches the real carry, the result is ready after one clock. When any guess is wrong, the affected sections are added again with the real carries, and the result is ready after two clocks.

A requester pulses `start` with the two operands. The adder holds `busy` high while it works. It then raises `done` for one cycle. At that point the sum, the carry-out and a flag are valid. The flag shows whether the slow path was taken. The results stay in place until the next operation finishes.

The default setting is a 32-bit word in two 16-bit sections. The same block can be set up with four 16-bit sections to form a 64-bit adder. In that form, a single wrong guess at any of its three section boundaries makes the operation slow.

Top module: `spec_carry_adder`

## Requirements
- R1: When `done` is high, `{cout, sum}` equals the full-width sum of the accepted `a` and `b`, with `cout` as the carry out of the top bit.
- R2: The guess for the carry into section k (k ≥ 1) is the AND of operand bits k·SW−1 of `a` and `b`, where SW = WIDTH/SECTIONS. If every guess equals the real carry, `done` rises one clock after the edge that accepts `start`. For random operands with two sections, this happens in about three quarters of operations.
- R3: If any guess differs from the real carry, `done` rises two clocks after the accepting edge.
- R4: `mispredict` is 1 when the two-clock path was taken and 0 when the one-clock path was taken. It becomes valid in the cycle `done` is high.
- R5: `done` lasts one cycle. `busy` is high from the accepting edge up to, but not including, the `done` cycle.
- R6: A `start` that arrives while `busy` is high is ignored. The running operation keeps its operands and produces a single `done`.
- R7: After synchronous reset, `sum`, `cout`, `done`, `busy` and `mispredict` are all 0.
- R8: `sum`, `cout` and `mispredict` hold their values from one `done` until the next `done`. Changes on `a` and `b` without an accepted `start` have no effect on them.
- R9: With WIDTH=64 and SECTIONS=4, the one-clock path is taken only when all three boundary guesses are correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Requests an addition; accepted only when idle |
| a | input | WIDTH | First operand, sampled on the accepting edge |
| b | input | WIDTH | Second operand, sampled on the accepting edge |
| sum | output | WIDTH | Registered sum |
| cout | output | 1 | Registered carry out of the top bit |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High while an operation is in progress |
| mispredict | output | 1 | High when the last operation took the long path |

## Verification
Some properties are checked on every cycle. These cover the exactness of `{cout, sum}` at `done` and the agreement of `mispredict` with the number of busy cycles. They also cover the frozen operand registers while busy, the single-cycle `done`, and the held results. A further check confirms that a guess is always right when a boundary's bit pair is equal. The bench scenarios are needed to show the rest. They confirm that the latency follows the guess outcome for chosen carry patterns and that an ignored `start` leaves no trace. They also confirm that the short-path rate on random operands lands near the expected share in both the 32-bit and 64-bit set-ups.

// File: rtl/spec_carry_pkg.sv
`timescale 1ns/1ps
package spec_carry_pkg;
  // sequencing states of one addition
  typedef enum logic [1:0] {
    SC_IDLE = 2'd0,
    SC_EVAL = 2'd1,
    SC_FIX  = 2'd2
  } sc_state_e;
endpackage

// File: rtl/spec_carry_section.sv
`timescale 1ns/1ps
module spec_carry_section #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         gen,
  output logic         prop
);
  logic [W:0] with_cin;
  logic [W:0] no_cin;

  always_comb begin
    with_cin = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    no_cin   = {1'b0, a} + {1'b0, b};
    sum      = with_cin[W-1:0];
    // section creates a carry by itself
    gen      = no_cin[W];
    // section passes an incoming carry straight through
    prop     = &(a ^ b);
  end
endmodule

// File: rtl/spec_carry_resolve.sv
`timescale 1ns/1ps
module spec_carry_resolve #(
  parameter int N = 2
) (
  input  logic [N-1:0] gen,
  input  logic [N-1:0] prop,
  input  logic [N-1:0] est,
  output logic [N:0]   carry,
  output logic         mismatch
);
  // real carry into each section, resolved at section granularity
  always_comb begin
    carry[0] = 1'b0;
    for (int k = 0; k < N; k++) begin
      carry[k+1] = gen[k] | (prop[k] & carry[k]);
    end
    mismatch = |(est ^ carry[N-1:0]);
  end
endmodule

// File: rtl/spec_carry_ctrl.sv
`timescale 1ns/1ps
module spec_carry_ctrl
  import spec_carry_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic mismatch,
  output logic accept,
  output logic in_eval,
  output logic in_fix,
  output logic done_o,
  output logic busy_o
);
  sc_state_e state_q;

  assign accept  = (state_q == SC_IDLE) && start;
  assign in_eval = (state_q == SC_EVAL);
  assign in_fix  = (state_q == SC_FIX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SC_IDLE;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        SC_IDLE: if (start) begin
          state_q <= SC_EVAL;
          busy_o  <= 1'b1;
        end
        SC_EVAL: if (mismatch) begin
          state_q <= SC_FIX;
        end else begin
          state_q <= SC_IDLE;
          busy_o  <= 1'b0;
          done_o  <= 1'b1;
        end
        SC_FIX: begin
          state_q <= SC_IDLE;
          busy_o  <= 1'b0;
          done_o  <= 1'b1;
        end
        default: state_q <= SC_IDLE;
      endcase
    end
  end

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_busy_excl_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  p_accept_busy_r5: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy_o);
endmodule

// File: rtl/spec_carry_adder.sv
`timescale 1ns/1ps
module spec_carry_adder #(
  parameter int WIDTH    = 32,
  parameter int SECTIONS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             done,
  output logic             busy,
  output logic             mispredict
);
  localparam int SW = WIDTH / SECTIONS;

  logic [WIDTH-1:0]    opa_q, opb_q, sec_sum, sum_q;
  logic [SECTIONS-1:0] est, cin_sel, gen, prop, true_q;
  logic [SECTIONS:0]   true_c;
  logic                mismatch, accept, in_eval, in_fix;
  logic                cout_q, mis_q;

  generate
    for (genvar i = 0; i < SECTIONS; i++) begin : g_sec
      if (i == 0) begin : g_low
        assign est[i] = 1'b0;
      end else begin : g_up
        // guess from the top bit pair of the section below
        assign est[i] = opa_q[i*SW-1] & opb_q[i*SW-1];

        p_equal_bits_exact_r2: assert property (@(posedge clk) disable iff (rst)
          (busy && (opa_q[i*SW-1] == opb_q[i*SW-1])) |-> (est[i] == true_c[i]));
      end
      assign cin_sel[i] = in_fix ? true_q[i] : est[i];

      spec_carry_section #(.W(SW)) u_sec (
        .a    (opa_q[i*SW +: SW]),
        .b    (opb_q[i*SW +: SW]),
        .cin  (cin_sel[i]),
        .sum  (sec_sum[i*SW +: SW]),
        .gen  (gen[i]),
        .prop (prop[i])
      );
    end
  endgenerate

  spec_carry_resolve #(.N(SECTIONS)) u_resolve (
    .gen      (gen),
    .prop     (prop),
    .est      (est),
    .carry    (true_c),
    .mismatch (mismatch)
  );

  spec_carry_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .mismatch (mismatch),
    .accept   (accept),
    .in_eval  (in_eval),
    .in_fix   (in_fix),
    .done_o   (done),
    .busy_o   (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      opa_q  <= '0;
      opb_q  <= '0;
      true_q <= '0;
      sum_q  <= '0;
      cout_q <= 1'b0;
      mis_q  <= 1'b0;
    end else begin
      if (accept) begin
        opa_q  <= a;
        opb_q  <= b;
        true_q <= '0;
      end
      if (in_eval && mismatch) begin
        true_q <= true_c[SECTIONS-1:0];
      end
      if (in_eval && !mismatch) begin
        sum_q  <= sec_sum;
        cout_q <= true_c[SECTIONS];
        mis_q  <= 1'b0;
      end
      if (in_fix) begin
        sum_q  <= sec_sum;
        cout_q <= true_c[SECTIONS];
        mis_q  <= 1'b1;
      end
    end
  end

  assign sum        = sum_q;
  assign cout       = cout_q;
  assign mispredict = mis_q;

  p_sum_exact_r1: assert property (@(posedge clk) disable iff (rst)
    done |-> ({cout, sum} == ({1'b0, opa_q} + {1'b0, opb_q})));
  p_long_flag_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (mispredict == $past(busy, 2)));
  p_operands_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(opa_q) && $stable(opb_q)));
  p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |=> ($stable(sum) && $stable(cout) && $stable(mispredict)));
endmodule

// File: tb/spec_carry_adder_test.sv
`timescale 1ns/1ps
module spec_carry_adder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start32 = 1'b0, start64 = 1'b0;
  logic [31:0] a32 = '0, b32 = '0;
  logic [63:0] a64 = '0, b64 = '0;
  logic [31:0] sum32;
  logic [63:0] sum64;
  logic        cout32, done32, busy32, mis32;
  logic        cout64, done64, busy64, mis64;
  int          n_tests = 0, n_fail = 0;
  bit          wide = 1'b0;
  logic [63:0] o_sum;
  logic        o_cout, o_done, o_busy, o_mis;

  always #4 clk = ~clk;

  spec_carry_adder uut (
    .clk(clk), .rst(rst), .start(start32), .a(a32), .b(b32),
    .sum(sum32), .cout(cout32), .done(done32), .busy(busy32), .mispredict(mis32));

  spec_carry_adder #(.WIDTH(64), .SECTIONS(4)) uut64 (
    .clk(clk), .rst(rst), .start(start64), .a(a64), .b(b64),
    .sum(sum64), .cout(cout64), .done(done64), .busy(busy64), .mispredict(mis64));

  always_comb begin
    o_sum  = wide ? sum64  : {32'b0, sum32};
    o_cout = wide ? cout64 : cout32;
    o_done = wide ? done64 : done32;
    o_busy = wide ? busy64 : busy32;
    o_mis  = wide ? mis64  : mis32;
  end

  task automatic chk(input bit ok, input string req, input logic [64:0] act, input logic [64:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected long-path condition computed from the guess rule
  function automatic bit exp_miss(input bit w, input logic [63:0] x, input logic [63:0] y);
    int nb = w ? 4 : 2;
    bit m = 1'b0;
    for (int j = 1; j < nb; j++) begin
      logic [64:0] mask = (65'd1 << (16*j)) - 65'd1;
      logic [64:0] t = (({1'b0, x} & mask) + ({1'b0, y} & mask)) >> (16*j);
      bit g = x[16*j-1] & y[16*j-1];
      if (t[0] != g) m = 1'b1;
    end
    return m;
  endfunction

  // one operation; returns whether the short path was seen
  task automatic run_op(input bit w, input logic [63:0] x, input logic [63:0] y,
                        input string tag, output bit was_short);
    logic [64:0] t;
    logic [63:0] es;
    bit ec, em;
    int lat = 0;
    if (!w) begin x[63:32] = '0; y[63:32] = '0; end
    t  = {1'b0, x} + {1'b0, y};
    es = w ? t[63:0] : {32'b0, t[31:0]};
    ec = w ? t[64] : t[32];
    em = exp_miss(w, x, y);
    wide = w;
    @(negedge clk);
    if (w) begin a64 = x; b64 = y; start64 = 1'b1; end
    else begin a32 = x[31:0]; b32 = y[31:0]; start32 = 1'b1; end
    @(negedge clk);
    start32 = 1'b0; start64 = 1'b0;
    chk(o_busy == 1'b1, {tag, " R5 busy after accept"}, o_busy, 1);
    while (lat < 6) begin
      @(negedge clk);
      lat++;
      if (o_done) break;
    end
    chk(lat == (em ? 2 : 1), {tag, em ? " R3 long latency" : " R2 short latency"}, lat, em ? 2 : 1);
    chk(o_sum == es, {tag, " R1 sum"}, o_sum, es);
    chk(o_cout == ec, {tag, " R1 cout"}, o_cout, ec);
    chk(o_mis == em, {tag, " R4 mispredict"}, o_mis, em);
    chk(o_busy == 1'b0, {tag, " R5 busy low at done"}, o_busy, 0);
    if (w) begin a64 = ~x; b64 = ~y; end else begin a32 = ~x[31:0]; b32 = ~y[31:0]; end
    @(negedge clk);
    chk(o_done == 1'b0, {tag, " R5 done single cycle"}, o_done, 0);
    chk(o_sum == es && o_mis == em, {tag, " R8 result held"}, o_sum, es);
    was_short = !em;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(sum32 == 0 && cout32 == 0, "R7 reset sum/cout", {cout32, sum32}, 0);
    chk(done32 == 0 && busy32 == 0 && mis32 == 0, "R7 reset flags", {done32, busy32, mis32}, 0);
    chk(sum64 == 0 && done64 == 0 && busy64 == 0, "R7 reset wide", sum64, 0);
    rst = 1'b0;
  endtask

  task automatic t_directed32;
    bit s;
    run_op(0, 64'h0000_7FFF, 64'h0000_0001, "R2 top pair 00", s);
    run_op(0, 64'h0000_8000, 64'h0000_8000, "R2 top pair 11", s);
    run_op(0, 64'h0000_8000, 64'h0000_0001, "R2 differ no carry", s);
    run_op(0, 64'h0000_FFFF, 64'h0000_0001, "R3 differ with carry", s);
    run_op(0, 64'h1234_4000, 64'h0F0F_C000, "R3 lower carry", s);
  endtask

  task automatic t_overflow;
    bit s;
    run_op(0, 64'hFFFF_FFFF, 64'h0000_0001, "R1 wrap", s);
    run_op(0, 64'h8000_8000, 64'h8000_8000, "R1 top carry short", s);
  endtask

  task automatic t_busy_start;
    int dones = 0;
    wide = 1'b0;
    @(negedge clk);
    a32 = 32'h0000_FFFF; b32 = 32'h0000_0001; start32 = 1'b1;
    @(negedge clk);
    a32 = 32'h0000_0005; b32 = 32'h0000_0006;
    @(negedge clk);
    chk(busy32 == 1'b1, "R6 still busy", busy32, 1);
    start32 = 1'b0;
    @(negedge clk);
    chk(done32 == 1'b1, "R6 first op completes", done32, 1);
    chk(sum32 == 32'h0001_0000, "R6 operands kept", sum32, 32'h0001_0000);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done32) dones++;
    end
    chk(dones == 0, "R6 no second done", dones, 0);
    chk(sum32 == 32'h0001_0000, "R6 ignored start left no result", sum32, 32'h0001_0000);
  endtask

  task automatic t_hold;
    logic [31:0] keep = sum32;
    bit km = mis32;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      a32 = $urandom; b32 = $urandom;
    end
    @(negedge clk);
    chk(sum32 == keep && mis32 == km && done32 == 0, "R8 inputs without start", sum32, keep);
  endtask

  task automatic t_random32;
    int shorts = 0;
    bit s;
    for (int k = 0; k < 400; k++) begin
      run_op(0, {32'b0, 32'($urandom)}, {32'b0, 32'($urandom)}, "rand32", s);
      if (s) shorts++;
    end
    chk(shorts >= 260 && shorts <= 340, "R2 short-path share", shorts, 300);
  endtask

  task automatic t_wide64;
    bit s;
    int shorts = 0;
    run_op(1, 64'h0123_4567_89AB_0001, 64'h0001_0001_0001_0001, "R9 all guesses right", s);
    run_op(1, 64'h0000_0000_FFFF_0000, 64'h0000_0000_0001_0000, "R9 middle boundary wrong", s);
    run_op(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, "R9 all boundaries wrong", s);
    run_op(1, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, "R9 pairs 11", s);
    for (int k = 0; k < 300; k++) begin
      run_op(1, {32'($urandom), 32'($urandom)}, {32'($urandom), 32'($urandom)}, "R9 rand64", s);
      if (s) shorts++;
    end
    chk(shorts >= 90 && shorts <= 165, "R9 short-path share", shorts, 127);
  endtask

  initial begin
    t_reset();
    t_directed32();
    t_overflow();
    t_busy_start();
    t_hold();
    t_random32();
    t_wide64();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule